// File: doc/BRIEF.md
# AFSK Tone Modulator with NRZI Coding

This block plays a packet out of a byte buffer as audio-frequency shift keyed tones. Each bit of the packet is NRZI coded. A 0 bit makes the oscillator swap to the other of two tones. A 1 bit keeps the tone it already has. A numerically controlled oscillator produces the tones. It has a 16-bit phase accumulator and a computed 512-entry sine table, and each table sample goes straight to an 8-bit PWM duty-cycle output.

The host first writes the packet into an external synchronous buffer. It then pulses `start_i` with the packet length in bits. From then on the block reads one byte per eight bits through its read port. It holds `busy_o` and the push-to-talk line `ptt_o` high while the samples go out. On the sample strobe after the last bit it drops both lines and parks the duty value at mid-scale.

Output samples are paced by a divider. Its default of 256 clocks per sample matches one overflow of an 8-bit PWM counter. A bit lasts a fixed number of samples, 36 by default, which gives 1200 baud.

Top module: `afsk_nrzi_mod`

## Requirements
- R1: After reset, `busy_o`, `ptt_o` and `rd_en_o` are 0 and `duty_o` is 0x80.
- R2: A `start_i` pulse while idle raises `busy_o` and `ptt_o` at the next edge and captures `len_bits_i`. It restarts the sample divider, so the first sample strobe falls SAMPLE_DIV clocks after the start edge.
- R3: `start_i` is ignored while `busy_o` is high. Neither the packet length nor the sample stream changes.
- R4: `duty_o` changes only on a sample strobe, once every SAMPLE_DIV clocks, and each bit spans exactly SAMPLES_PER_BIT strobes.
- R5: At start the 16-bit phase accumulator clears and the increment is set to INC_LO (1800). On every sample the active increment is added, with wrap modulo 65536.
- R6: On the first sample of each bit, a 0 bit swaps the increment between INC_LO (1800) and INC_HI (2200) before it is added. A 1 bit leaves the increment unchanged.
- R7: Packet bit p is bit (p mod 8) of buffer byte p/8, so bits leave LSB first.
- R8: Each sample is sine(k) with k = phase[15:7]. With m = k mod 256 and t = m*(256-m), let s = (2032*t) div (327680 - 4*t). Then sine(k) = 128+s for k < 256 and 128-s otherwise.
- R9: Each byte is fetched once. `rd_en_o` is high for one clock with `rd_addr_o` holding the byte index, and the data is taken from `rd_data_i` one clock later (SAMPLE_DIV must be at least 3). The fetch of byte 0 is issued at start, and each later fetch at the strobe that ends the previous byte. Only bytes that hold packet bits are read.
- R10: On the strobe after the last sample of the last bit, `busy_o` and `ptt_o` fall together and `duty_o` returns to 0x80.
- R11: A zero length issues no fetch and produces no tone sample. The block releases on the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock start pulse |
| len_bits_i | input | LEN_W | Packet length in bits, taken on start |
| rd_en_o | output | 1 | Buffer read request |
| rd_addr_o | output | LEN_W-3 | Byte index of the read |
| rd_data_i | input | 8 | Byte returned one clock after the request |
| duty_o | output | 8 | PWM duty value (tone sample) |
| busy_o | output | 1 | Packet in progress |
| ptt_o | output | 1 | Push-to-talk, high while transmitting |

## Verification
The bench builds the block with SAMPLE_DIV = 4 and SAMPLES_PER_BIT = 5. The table, accumulator and tone increments keep their full default sizes. The short bit time lets the bench sweep every packet length from 0 to 40 bits. That sweep covers every bit position within a byte, every byte boundary, and the empty packet. Further runs with all-zero, all-one and alternating buffers drive the NRZI toggle on every bit and on no bit. A start pulse injected mid-packet shows that a second start has no effect.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

    localparam logic [7:0] DUTY_REST = 8'h80;

    // Integer half-wave sine approximation, unsigned and centred on 128.
    function automatic logic [7:0] sine_point(input int idx, input int entries);
        int half;
        int m;
        int t;
        int s;
        half = entries / 2;
        m    = idx % half;
        t    = m * (half - m);
        s    = (127 * 16 * t) / (5 * half * half - 4 * t);
        if (idx < half) begin
            return 8'(128 + s);
        end
        return 8'(128 - s);
    endfunction

endpackage

// File: rtl/afsk_sample_clock.sv
module afsk_sample_clock #(
    parameter int SAMPLE_DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 2;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } clk_st_t;

    clk_st_t st_d, st_q;

    assign tick = (st_q.cnt == CNT_LAST);

    always_comb begin
        st_d = st_q;
        if (restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/afsk_bit_seq.sv
module afsk_bit_seq #(
    parameter int SAMPLES_PER_BIT = 36,
    parameter int LEN_W           = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   len_bits,
    input  logic               tick,
    input  logic [7:0]         rd_data,
    output logic               rd_en,
    output logic [LEN_W-4:0]   rd_addr,
    output logic               busy,
    output logic               ptt,
    output logic               restart,
    output logic               samp_en,
    output logic               bit_first,
    output logic               bit_val,
    output logic               finish
);
    localparam int ADDR_W = LEN_W - 3;
    localparam int SAMP_W = (SAMPLES_PER_BIT > 2) ? $clog2(SAMPLES_PER_BIT) : 1;
    localparam logic [SAMP_W-1:0] SAMP_LAST = SAMP_W'(SAMPLES_PER_BIT - 1);

    typedef struct packed {
        logic              busy;
        logic              ptt;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  pos;
        logic [SAMP_W-1:0] samp;
        logic [7:0]        shreg;
        logic              rd_en;
        logic [ADDR_W-1:0] rd_addr;
        logic              load;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [LEN_W-1:0] pos_next;
    logic             accept;
    logic             at_end;

    assign accept    = start && !st_q.busy;
    assign at_end    = (st_q.pos == st_q.len);
    assign pos_next  = st_q.pos + 1'b1;

    assign restart   = accept;
    assign samp_en   = st_q.busy && tick && !at_end;
    assign finish    = st_q.busy && tick && at_end;
    assign bit_first = (st_q.samp == '0);
    assign bit_val   = st_q.shreg[0];
    assign rd_en     = st_q.rd_en;
    assign rd_addr   = st_q.rd_addr;
    assign busy      = st_q.busy;
    assign ptt       = st_q.ptt;

    always_comb begin
        st_d       = st_q;
        st_d.rd_en = 1'b0;
        st_d.load  = st_q.rd_en;
        if (st_q.load) begin
            st_d.shreg = rd_data;
        end
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.ptt  = 1'b1;
            st_d.len  = len_bits;
            st_d.pos  = '0;
            st_d.samp = '0;
            if (len_bits != '0) begin
                st_d.rd_en   = 1'b1;
                st_d.rd_addr = '0;
            end
        end else if (finish) begin
            st_d.busy = 1'b0;
            st_d.ptt  = 1'b0;
        end else if (samp_en) begin
            if (st_q.samp == SAMP_LAST) begin
                st_d.samp = '0;
                st_d.pos  = pos_next;
                if ((pos_next[2:0] == 3'd0) && (pos_next < st_q.len)) begin
                    st_d.rd_en   = 1'b1;
                    st_d.rd_addr = pos_next[LEN_W-1:3];
                end else begin
                    st_d.shreg = {1'b0, st_q.shreg[7:1]};
                end
            end else begin
                st_d.samp = st_q.samp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/afsk_nco.sv
module afsk_nco
    import afsk_pkg::*;
#(
    parameter int PHASE_W   = 16,
    parameter int TBL_AW    = 9,
    parameter int IDX_SHIFT = 7,
    parameter int INC_LO    = 1800,
    parameter int INC_HI    = 2200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       samp_en,
    input  logic       bit_first,
    input  logic       bit_val,
    input  logic       finish,
    output logic [7:0] duty
);
    localparam int TBL_N = 1 << TBL_AW;
    localparam logic [PHASE_W-1:0] INC_LO_V  = PHASE_W'(INC_LO);
    localparam logic [PHASE_W-1:0] INC_SWAP  = PHASE_W'(INC_LO ^ INC_HI);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [PHASE_W-1:0] inc;
        logic [7:0]         duty;
    } nco_st_t;

    localparam nco_st_t NCO_RST = '{phase: '0, inc: INC_LO_V, duty: DUTY_REST};

    nco_st_t st_d, st_q;
    logic [7:0] wave [TBL_N];
    logic [PHASE_W-1:0] inc_use;
    logic [PHASE_W-1:0] phase_sum;

    for (genvar g = 0; g < TBL_N; g++) begin : g_wave
        assign wave[g] = sine_point(g, TBL_N);
    end

    assign inc_use   = (bit_first && !bit_val) ? (st_q.inc ^ INC_SWAP) : st_q.inc;
    assign phase_sum = st_q.phase + inc_use;
    assign duty      = st_q.duty;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.phase = '0;
            st_d.inc   = INC_LO_V;
            st_d.duty  = DUTY_REST;
        end else if (samp_en) begin
            st_d.inc   = inc_use;
            st_d.phase = phase_sum;
            st_d.duty  = wave[phase_sum[IDX_SHIFT +: TBL_AW]];
        end else if (finish) begin
            st_d.duty  = DUTY_REST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= NCO_RST;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/afsk_nrzi_mod.sv
module afsk_nrzi_mod #(
    parameter int SAMPLE_DIV      = 256,
    parameter int SAMPLES_PER_BIT = 36,
    parameter int LEN_W           = 16,
    parameter int PHASE_W         = 16,
    parameter int TBL_AW          = 9,
    parameter int IDX_SHIFT       = 7,
    parameter int INC_LO          = 1800,
    parameter int INC_HI          = 2200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   len_bits_i,
    output logic               rd_en_o,
    output logic [LEN_W-4:0]   rd_addr_o,
    input  logic [7:0]         rd_data_i,
    output logic [7:0]         duty_o,
    output logic               busy_o,
    output logic               ptt_o
);
    logic sample_tick;
    logic restart;
    logic samp_en;
    logic bit_first;
    logic bit_val;
    logic finish;

    afsk_sample_clock #(
        .SAMPLE_DIV (SAMPLE_DIV)
    ) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (sample_tick)
    );

    afsk_bit_seq #(
        .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
        .LEN_W           (LEN_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .len_bits  (len_bits_i),
        .tick      (sample_tick),
        .rd_data   (rd_data_i),
        .rd_en     (rd_en_o),
        .rd_addr   (rd_addr_o),
        .busy      (busy_o),
        .ptt       (ptt_o),
        .restart   (restart),
        .samp_en   (samp_en),
        .bit_first (bit_first),
        .bit_val   (bit_val),
        .finish    (finish)
    );

    afsk_nco #(
        .PHASE_W   (PHASE_W),
        .TBL_AW    (TBL_AW),
        .IDX_SHIFT (IDX_SHIFT),
        .INC_LO    (INC_LO),
        .INC_HI    (INC_HI)
    ) u_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .samp_en   (samp_en),
        .bit_first (bit_first),
        .bit_val   (bit_val),
        .finish    (finish),
        .duty      (duty_o)
    );
endmodule

// File: rtl/afsk_nrzi_chk.sv
module afsk_nrzi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       rd_en_o,
    input logic [7:0] duty_o,
    input logic       tick
);
    // R1
    idle_duty_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> duty_o == 8'h80);

    // R4
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(duty_o));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tick));

    // R9
    fetch_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> busy_o);

    // R9
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o);
endmodule

bind afsk_nrzi_mod afsk_nrzi_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .rd_en_o (rd_en_o),
    .duty_o  (duty_o),
    .tick    (sample_tick)
);

// File: tb/tb_afsk_nrzi_mod.sv
module tb_afsk_nrzi_mod;
    localparam int DIV = 4;
    localparam int SPB = 5;
    localparam int LW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] len_bits = '0;
    logic          rd_en;
    logic [LW-4:0] rd_addr;
    logic [7:0]    rd_data = '0;
    logic [7:0]    duty;
    logic          busy;
    logic          ptt;

    logic [7:0] mem [8];
    int checks = 0;
    int errors = 0;
    int fetch_cnt = 0;
    int fetch_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    afsk_nrzi_mod #(
        .SAMPLE_DIV      (DIV),
        .SAMPLES_PER_BIT (SPB),
        .LEN_W           (LW)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .len_bits_i (len_bits),
        .rd_en_o    (rd_en),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data),
        .duty_o     (duty),
        .busy_o     (busy),
        .ptt_o      (ptt)
    );

    // synchronous buffer model: data valid the clock after the request
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr[2:0]];
    end

    // R9: fetches are in ascending byte order, one per byte
    always @(negedge clk) begin
        if (rd_en) begin
            if (int'(rd_addr) != fetch_cnt) fetch_bad++;
            fetch_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_sine(input int k);
        int m;
        int t;
        int s;
        m = k % 256;
        t = m * (256 - m);
        s = (2032 * t) / (327680 - 4 * t);
        return (k < 256) ? 8'(128 + s) : 8'(128 - s);
    endfunction

    task automatic fill(input int pat);
        for (int i = 0; i < 8; i++) begin
            case (pat)
                0:       mem[i] = 8'h00;
                1:       mem[i] = 8'hFF;
                2:       mem[i] = (i % 2 == 0) ? 8'h55 : 8'hA3;
                default: mem[i] = 8'(i * 73 + 29);
            endcase
        end
    endtask

    task automatic run_packet(input int len, input int pat, input bit inject);
        int phase;
        int inc;
        int nsamp;
        int bidx;
        int bv;
        logic [7:0] expv;
        logic [7:0] prev;
        fill(pat);
        fetch_cnt = 0;
        fetch_bad = 0;
        phase = 0;
        inc = 1800;
        prev = 8'h80;
        nsamp = len * SPB;
        @(negedge clk);
        start = 1'b1;
        len_bits = LW'(len);
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && ptt === 1'b1, "R2", int'({busy, ptt}), 3);
        for (int s = 0; s < nsamp; s++) begin
            bidx = s / SPB;
            bv = (mem[bidx / 8] >> (bidx % 8)) & 1;
            if ((s % SPB == 0) && bv == 0) inc = inc ^ (1800 ^ 2200);
            phase = (phase + inc) & 16'hFFFF;
            expv = ref_sine((phase >> 7) & 511);
            for (int c = 0; c < DIV - 1; c++) begin
                @(negedge clk);
                if (inject && s == 2 && c == 0) begin
                    start = 1'b1;
                    len_bits = LW'(len + 3);
                end else begin
                    start = 1'b0;
                    len_bits = LW'(len);
                end
            end
            check(duty === prev, "R4", int'(duty), int'(prev));
            @(negedge clk);
            if (inject)
                check(duty === expv, "R3", int'(duty), int'(expv));
            else
                check(duty === expv, "R6 R7 R8 R5", int'(duty), int'(expv));
            check(busy === 1'b1, "R4", int'(busy), 1);
            prev = expv;
        end
        repeat (DIV - 1) @(negedge clk);
        check(busy === 1'b1 && duty === prev, "R4", int'(duty), int'(prev));
        @(negedge clk);
        if (len == 0)
            check(busy === 1'b0 && ptt === 1'b0 && duty === 8'h80, "R11", int'({busy, ptt, duty}), 128);
        else
            check(busy === 1'b0 && ptt === 1'b0 && duty === 8'h80, "R10", int'({busy, ptt, duty}), 128);
        check(fetch_cnt == (len + 7) / 8 && fetch_bad == 0, "R9", fetch_cnt, (len + 7) / 8);
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && duty === 8'h80, "R10", int'(duty), 128);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && ptt === 1'b0 && rd_en === 1'b0 && duty === 8'h80,
              "R1", int'({busy, ptt, rd_en, duty}), 128);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && duty === 8'h80, "R1", int'(duty), 128);
        for (int len = 0; len <= 40; len++) run_packet(len, 3, 1'b0);
        for (int pat = 0; pat < 3; pat++) begin
            run_packet(1, pat, 1'b0);
            run_packet(8, pat, 1'b0);
            run_packet(9, pat, 1'b0);
            run_packet(23, pat, 1'b0);
        end
        run_packet(17, 3, 1'b1);
        run_packet(6, 2, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule